// File: doc/BRIEF.md
# Volume Button Auto-Repeat Controller

This block turns two active-high push buttons, one for louder and one for quieter, into stepped changes of a stereo attenuation setting. Each channel holds a 6-bit attenuation code from 0 to 63. A larger code means a quieter output, so the louder button lowers both codes and the quieter button raises them. A new press takes effect at once. If a button is still held, the step repeats after a long initial delay and then at a shorter fixed interval. Both delays are counted in ticks of a free-running 1 ms strobe.

A button-interrupt output reports a pressed button to the host. The block masks this output from the first step of a press until a repeat check finds no button active. This stops a held button from raising a stream of interrupts. A load port lets the host write both codes directly, and both codes are always visible on the outputs.

Top module: `vol_repeat_ctrl`

## Requirements
- R1: A synchronous active-high reset sets both codes to 0, stops any timing in progress and leaves the interrupt unmasked.
- R2: A press seen while no hold is being tracked applies one step on the third rising clock edge after the button input changes, because of a two-flop synchronizer. The louder button (btn_up_i) decrements both codes and the quieter button (btn_dn_i) increments both.
- R3: A step saturates each code on its own, at 0 when decrementing and at 63 when incrementing.
- R4: The first repeat check falls on the 400th tick after the step that started the hold, not earlier.
- R5: After a repeat step, the next check falls on the 100th tick after that step.
- R6: When both buttons count at one step, the decrement is applied first and then the increment. The net change is zero except at the saturation limits: a code at 0 ends at 1 and a code at 63 stays at 63.
- R7: irq_o is high when a synchronized button is active and the interrupt is unmasked. A step taken with no hold tracked masks it. It is unmasked again only by a check that finds no button pending or active.
- R8: Each new press seen while waiting is latched into a status bit. That bit drives a step at the next check even if the button has been released, and it is cleared once acted on, so it causes only one step.
- R9: load_i writes load_left_i and load_right_i into the codes on the next edge. A load wins over a step computed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle 1 ms strobe |
| btn_up_i | input | 1 | Louder button, asynchronous, active high |
| btn_dn_i | input | 1 | Quieter button, asynchronous, active high |
| load_i | input | 1 | Write both codes from the load inputs |
| load_left_i | input | 6 | Left code to load |
| load_right_i | input | 6 | Right code to load |
| left_o | output | 6 | Left attenuation code |
| right_o | output | 6 | Right attenuation code |
| irq_o | output | 1 | Button interrupt, masked while a hold is tracked |

## Verification
The assertions assume that tick_i is a single-cycle strobe and that the codes move only through a load or a step. They also assume that a step with no hold tracked always coincides with an unmasked, visible interrupt. The stimulus keeps tick_i high for one cycle and low for the next. It holds every button change for at least three clocks so that the synchronizer passes it. It changes buttons and raises load_i only on falling edges, with load_i high for a single cycle.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_NEXT  = 2'd2
    } vrc_state_e;

    // bit positions inside the two-bit button vectors
    localparam int BTN_UP = 1;
    localparam int BTN_DN = 0;
    localparam int NUM_BTN = 2;
    localparam int NUM_CH  = 2;
    localparam int CH_LEFT  = 1;
    localparam int CH_RIGHT = 0;
endpackage

// File: rtl/vrc_sync.sv
module vrc_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[b];
                stab_q <= meta_q;
            end
        end
        assign sync_o[b] = stab_q;
    end
endmodule

// File: rtl/vrc_lvl_step.sv
module vrc_lvl_step #(
    parameter int W = 6
) (
    input  logic [W-1:0] lvl_i,
    input  logic         dec_i,
    input  logic         inc_i,
    output logic [W-1:0] lvl_o
);
    localparam logic [W-1:0] LVL_MAX = {W{1'b1}};

    logic [W-1:0] after_dec;

    always_comb begin
        after_dec = lvl_i;
        if (dec_i && lvl_i != '0) begin
            after_dec = lvl_i - W'(1);
        end
        lvl_o = after_dec;
        if (inc_i && after_dec != LVL_MAX) begin
            lvl_o = after_dec + W'(1);
        end
    end
endmodule

// File: rtl/vol_repeat_ctrl.sv
module vol_repeat_ctrl
    import vrc_pkg::*;
#(
    parameter int LVL_W     = 6,
    parameter int CNT_W     = 9,
    parameter int FIRST_DLY = 400,
    parameter int NEXT_DLY  = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             btn_up_i,
    input  logic             btn_dn_i,
    input  logic             load_i,
    input  logic [LVL_W-1:0] load_left_i,
    input  logic [LVL_W-1:0] load_right_i,
    output logic [LVL_W-1:0] left_o,
    output logic [LVL_W-1:0] right_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] FIRST_LIM = CNT_W'(FIRST_DLY - 1);
    localparam logic [CNT_W-1:0] NEXT_LIM  = CNT_W'(NEXT_DLY - 1);

    typedef struct packed {
        vrc_state_e                     st;
        logic [CNT_W-1:0]               cnt;
        logic [NUM_BTN-1:0]             pend;
        logic [NUM_BTN-1:0]             seen;
        logic                           mask;
        logic [NUM_CH-1:0][LVL_W-1:0]   lvl;
    } vrc_regs_t;

    vrc_regs_t q, d;

    logic [NUM_BTN-1:0]           btn_s;
    logic [NUM_BTN-1:0]           rise;
    logic [NUM_BTN-1:0]           btn_now;
    logic [CNT_W-1:0]             lim;
    logic                         chk;
    logic                         step;
    logic [NUM_CH-1:0][LVL_W-1:0] lvl_step;

    vrc_sync #(.N(NUM_BTN)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({btn_up_i, btn_dn_i}),
        .sync_o  (btn_s)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        vrc_lvl_step #(.W(LVL_W)) u_step (
            .lvl_i (q.lvl[c]),
            .dec_i (step & btn_now[BTN_UP]),
            .inc_i (step & btn_now[BTN_DN]),
            .lvl_o (lvl_step[c])
        );
    end

    always_comb begin
        rise    = btn_s & ~q.seen;
        btn_now = q.pend | btn_s;
        lim     = (q.st == ST_FIRST) ? FIRST_LIM : NEXT_LIM;
        chk     = tick_i && (q.st != ST_IDLE) && (q.cnt == lim);
        step    = (|btn_now) && ((q.st == ST_IDLE) || chk);

        d      = q;
        d.seen = btn_s;
        d.pend = q.pend | rise;

        if (step) begin
            d.pend = '0;
            d.cnt  = '0;
            d.mask = 1'b1;
            d.st   = (q.st == ST_IDLE) ? ST_FIRST : ST_NEXT;
            d.lvl  = lvl_step;
        end else if (chk) begin
            d.pend = '0;
            d.cnt  = '0;
            d.mask = 1'b0;
            d.st   = ST_IDLE;
        end else if (tick_i && q.st != ST_IDLE) begin
            d.cnt = q.cnt + CNT_W'(1);
        end

        if (load_i) begin
            d.lvl[CH_LEFT]  = load_left_i;
            d.lvl[CH_RIGHT] = load_right_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st   <= ST_IDLE;
            q.cnt  <= '0;
            q.pend <= '0;
            q.seen <= '0;
            q.mask <= 1'b0;
            q.lvl  <= '0;
        end else begin
            q <= d;
        end
    end

    assign left_o  = q.lvl[CH_LEFT];
    assign right_o = q.lvl[CH_RIGHT];
    assign irq_o   = ~q.mask & (|btn_s);
endmodule

// File: rtl/vol_repeat_ctrl_chk.sv
module vol_repeat_ctrl_chk #(
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_i,
    input logic             load_i,
    input logic [LVL_W-1:0] load_left_i,
    input logic [LVL_W-1:0] load_right_i,
    input logic [LVL_W-1:0] left_o,
    input logic [LVL_W-1:0] right_o,
    input logic             irq_o
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(load_i) |->
            (left_o == $past(load_left_i)) && (right_o == $past(load_right_i)));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(load_i) |->
            ((int'(left_o) - int'($past(left_o))) inside {-1, 0, 1}) &&
            ((int'(right_o) - int'($past(right_o))) inside {-1, 0, 1}));

    // R2
    step_cause_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(load_i) &&
            ((left_o != $past(left_o)) || (right_o != $past(right_o))) |->
            ($past(tick_i) || $past(irq_o)));

    // R7
    irq_masks_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && irq_o |=> !irq_o);

    // R6
    same_dir_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(load_i) |->
            !((left_o > $past(left_o)) && (right_o < $past(right_o))) &&
            !((left_o < $past(left_o)) && (right_o > $past(right_o))));
endmodule

bind vol_repeat_ctrl vol_repeat_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick_i),
    .load_i       (load_i),
    .load_left_i  (load_left_i),
    .load_right_i (load_right_i),
    .left_o       (left_o),
    .right_o      (right_o),
    .irq_o        (irq_o)
);

// File: tb/vol_repeat_ctrl_tb_top.sv
module vol_repeat_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       btn_up_i = 1'b0;
    logic       btn_dn_i = 1'b0;
    logic       load_i = 1'b0;
    logic [5:0] load_left_i = '0;
    logic [5:0] load_right_i = '0;
    logic [5:0] left_o;
    logic [5:0] right_o;
    logic       irq_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    vol_repeat_ctrl dut_i (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .btn_up_i     (btn_up_i),
        .btn_dn_i     (btn_dn_i),
        .load_i       (load_i),
        .load_left_i  (load_left_i),
        .load_right_i (load_right_i),
        .left_o       (left_o),
        .right_o      (right_o),
        .irq_o        (irq_o)
    );

    task automatic clk_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        repeat (n) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic chk_lv(input string req, input logic [5:0] el, input logic [5:0] er);
        checks++;
        if (left_o !== el || right_o !== er) begin
            failures++;
            $display("FAIL %s: levels actual=%0d/%0d expected=%0d/%0d", req, left_o, right_o, el, er);
        end
    endtask

    task automatic chk_irq(input string req, input logic e);
        checks++;
        if (irq_o !== e) begin
            failures++;
            $display("FAIL %s: irq actual=%0b expected=%0b", req, irq_o, e);
        end
    endtask

    task automatic load(input logic [5:0] l, input logic [5:0] r);
        load_i = 1'b1; load_left_i = l; load_right_i = r;
        clk_n(1);
        load_i = 1'b0;
    endtask

    task automatic release_all(input int ticks);
        btn_up_i = 1'b0; btn_dn_i = 1'b0;
        clk_n(3);
        tick_n(ticks);
    endtask

    task automatic t_reset;
        rst = 1'b1; clk_n(3); rst = 1'b0; clk_n(1);
        chk_lv("R1 reset", 6'd0, 6'd0);
        chk_irq("R1 reset irq idle", 1'b0);
    endtask

    task automatic t_tap;
        load(6'd10, 6'd20);
        chk_lv("R9 load", 6'd10, 6'd20);
        btn_dn_i = 1'b1; clk_n(2);
        chk_irq("R7 irq on press", 1'b1);
        clk_n(1);
        chk_lv("R2 down step", 6'd11, 6'd21);
        chk_irq("R7 masked after step", 1'b0);
        btn_dn_i = 1'b0; clk_n(3);
        tick_n(399);
        chk_lv("R4 no early repeat", 6'd11, 6'd21);
        tick_n(1);
        chk_lv("R8 acted press cleared", 6'd11, 6'd21);
        btn_up_i = 1'b1; clk_n(2);
        chk_irq("R7 rearmed after release", 1'b1);
        clk_n(1);
        chk_lv("R2 up step", 6'd10, 6'd20);
        release_all(400);
    endtask

    task automatic t_hold;
        load(6'd60, 6'd61);
        btn_dn_i = 1'b1; clk_n(3);
        chk_lv("R2 hold first step", 6'd61, 6'd62);
        tick_n(399);
        chk_lv("R4 before first repeat", 6'd61, 6'd62);
        chk_irq("R7 masked while held", 1'b0);
        tick_n(1);
        chk_lv("R4 first repeat", 6'd62, 6'd63);
        tick_n(99);
        chk_lv("R5 before next repeat", 6'd62, 6'd63);
        tick_n(1);
        chk_lv("R5 next repeat R3 top", 6'd63, 6'd63);
        tick_n(100);
        chk_lv("R3 saturate 63", 6'd63, 6'd63);
        release_all(100);
        load(6'd1, 6'd0);
        btn_up_i = 1'b1; clk_n(3);
        chk_lv("R3 saturate 0", 6'd0, 6'd0);
        release_all(400);
    endtask

    task automatic t_both;
        load(6'd0, 6'd63);
        btn_up_i = 1'b1; btn_dn_i = 1'b1; clk_n(3);
        chk_lv("R6 both at limits", 6'd1, 6'd63);
        tick_n(400);
        chk_lv("R6 both repeat", 6'd1, 6'd63);
        release_all(100);
        load(6'd30, 6'd40);
        btn_up_i = 1'b1; btn_dn_i = 1'b1; clk_n(3);
        chk_lv("R6 both net zero", 6'd30, 6'd40);
        release_all(400);
    endtask

    task automatic t_latch;
        load(6'd20, 6'd20);
        btn_dn_i = 1'b1; clk_n(3); btn_dn_i = 1'b0; clk_n(3);
        chk_lv("R2 tap step", 6'd21, 6'd21);
        tick_n(200);
        btn_up_i = 1'b1; clk_n(3); btn_up_i = 1'b0; clk_n(3);
        chk_lv("R8 waits for check", 6'd21, 6'd21);
        chk_irq("R7 still masked", 1'b0);
        tick_n(200);
        chk_lv("R8 latched press applied", 6'd20, 6'd20);
        tick_n(100);
        chk_lv("R8 status cleared", 6'd20, 6'd20);
        btn_dn_i = 1'b1; clk_n(2);
        chk_irq("R7 rearmed", 1'b1);
        clk_n(1);
        chk_lv("R2 after rearm", 6'd21, 6'd21);
        release_all(400);
    endtask

    task automatic t_load_prio;
        btn_dn_i = 1'b1; clk_n(2);
        load_i = 1'b1; load_left_i = 6'd7; load_right_i = 6'd9;
        clk_n(1);
        load_i = 1'b0;
        chk_lv("R9 load beats step", 6'd7, 6'd9);
        release_all(400);
        chk_lv("R9 load kept", 6'd7, 6'd9);
    endtask

    task automatic t_reset_mid;
        btn_up_i = 1'b1; clk_n(3);
        rst = 1'b1; clk_n(2); rst = 1'b0; btn_up_i = 1'b0; clk_n(1);
        chk_lv("R1 reset mid hold", 6'd0, 6'd0);
        clk_n(3);
        btn_dn_i = 1'b1; clk_n(2);
        chk_irq("R1 unmasked after reset", 1'b1);
        clk_n(1);
        chk_lv("R1 step after reset", 6'd1, 6'd1);
        release_all(400);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clk_n(1);
        t_reset();
        t_tap();
        t_hold();
        t_both();
        t_latch();
        t_load_prio();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule